// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath half of a small 32-bit processor that runs each instruction over several clock cycles. It has one memory port that serves both instruction fetch and data access, and a single ALU. Across the cycles of one instruction, that ALU computes the next sequential PC, the branch target, the load/store address and the arithmetic result. Holding registers sit behind the memory (instruction register and memory data register), behind the register file (two operand registers) and behind the ALU (result register). A value produced in one cycle is therefore consumed in the next.

The block makes no decisions of its own. An external sequencer drives every select, enable and write strobe in every cycle. In return the block gives the sequencer the opcode and function fields of the held instruction and the ALU zero flag. The supported instruction subset is word load, word store, register add/subtract/and/or/set-less-than, branch-if-equal and absolute jump. It is built from a shared package, a register file, an ALU and a program-counter unit.

Top module: `mcdp_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, the PC and the instruction, memory-data, operand and ALU-result registers become zero, and so do all register-file entries. After reset, with all controls low, `mem_addr`, `mem_wdata`, `opcode` and `funct` read 0 and `zero` reads 1.
- R2: When `ctl_ir_we` is 1 at an edge, the instruction register loads `mem_rdata`. Otherwise it keeps its value. `opcode` shows bits 31:26 of the held instruction and `funct` shows bits 5:0.
- R3: The ALU's first operand is the PC when `ctl_opa_reg`=0 and operand register A when it is 1. With `ctl_opb_sel`=1 (constant 4), `ctl_alu_op`=add and `ctl_pc_src`=0, a `ctl_pc_we` edge loads PC+4 into the PC. `mem_addr` is the PC when `ctl_addr_sel`=0.
- R4: At every edge, operand A loads register[IR bits 25:21] and operand B loads register[IR bits 20:16]. `mem_wdata` always shows operand B, and `mem_wr` follows `ctl_mem_wr`.
- R5: `ctl_alu_op` encodings: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed set-less-than (result 1 or 0). `zero` is 1 exactly when the current ALU result is 0. The ALU-result register loads the ALU result at every edge.
- R6: With `ctl_opb_sel`=3, the second operand is the sign-extended IR bits 15:0 shifted left by 2. Added to the PC, this forms the branch target, which uses the already incremented PC.
- R7: With `ctl_opb_sel`=2, the second operand is the sign-extended IR bits 15:0, so A plus it forms the load/store address. When `ctl_addr_sel`=1, `mem_addr` shows the ALU-result register.
- R8: With `ctl_br_en`=1 and `ctl_pc_src`=1, the PC loads the ALU-result register at the edge only if `zero` is 1. If `zero` is 0 and `ctl_pc_we`=0, the PC holds.
- R9: With `ctl_pc_src`=2 and `ctl_pc_we`=1, the PC loads the upper 4 PC bits joined with IR bits 25:0 and two zero bits.
- R10: When `ctl_rf_we`=1, the register file writes at the edge that ends the cycle. The destination is IR bits 20:16 when `ctl_dst_rd`=0 and IR bits 15:11 when it is 1. The data is the ALU-result register when `ctl_wb_mem`=0 and the memory-data register when it is 1.
- R11: Register 0 always reads as zero, and writes addressed to it have no effect.
- R12: The memory-data register loads `mem_rdata` at every edge. The instruction register, and with it `opcode`/`funct`, does not change on edges where `ctl_ir_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pc_we | input | 1 | Unconditional PC write |
| ctl_br_en | input | 1 | PC write qualified by `zero` |
| ctl_pc_src | input | 2 | PC source: 0 ALU result, 1 ALU-result register, 2 jump target |
| ctl_addr_sel | input | 1 | Memory address: 0 PC, 1 ALU-result register |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_ir_we | input | 1 | Instruction register load |
| ctl_rf_we | input | 1 | Register-file write |
| ctl_dst_rd | input | 1 | Destination field: 0 bits 20:16, 1 bits 15:11 |
| ctl_wb_mem | input | 1 | Write-back data: 0 ALU-result register, 1 memory-data register |
| ctl_opa_reg | input | 1 | ALU operand 1: 0 PC, 1 operand A |
| ctl_opb_sel | input | 2 | ALU operand 2: 0 B, 1 constant 4, 2 immediate, 3 immediate shifted by 2 |
| ctl_alu_op | input | 3 | ALU function code |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_wr | output | 1 | Memory write strobe |
| opcode | output | 6 | Held instruction bits 31:26 |
| funct | output | 6 | Held instruction bits 5:0 |
| zero | output | 1 | ALU result is zero |

## Verification
The bench acts as the sequencer and runs a short program through the block. The program covers loads of a positive and a negative constant and all five register operations on them. Set-less-than is run in both operand orders, which separates signed from unsigned comparison. Two branches take opposite outcomes, one jump skips stores, and a store uses a negative offset, which exposes any missing sign extension. A write to register 0 followed by a store of register 0 shows whether that register can be altered. Every cycle, the memory address, write data, opcode, function field and zero flag are compared with a behavioural model. At the end, the trace of fetch addresses and the final memory words reveal wrong PC sources, branch targets and write-back fields.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

    localparam int XLEN = 32;
    localparam int FLDW = 6;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        PCS_ALU  = 2'd0,
        PCS_HOLD = 2'd1,
        PCS_JUMP = 2'd2
    } pc_src_e;

    typedef enum logic [1:0] {
        OPB_REG      = 2'd0,
        OPB_FOUR     = 2'd1,
        OPB_IMM      = 2'd2,
        OPB_IMM_WORD = 2'd3
    } opb_sel_e;

    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] fn;
    } instr_t;

    function automatic logic [XLEN-1:0] imm_sext(input instr_t i);
        logic [15:0] f;
        f = {i.rd, i.shamt, i.fn};
        return {{(XLEN-16){f[15]}}, f};
    endfunction

    function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc, input instr_t i);
        return {pc[XLEN-1:XLEN-4], i.rs, i.rt, i.rd, i.shamt, i.fn, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                                 input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b);
        logic [XLEN-1:0] y;
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
            default: y = '0;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [1:NREGS-1];

    for (genvar g = 1; g < NREGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && wa == AW'(g)) begin
                regs[g] <= wd;
            end
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd))); // R10

endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
    import mcdp_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         is_zero
);

    always_comb begin
        y       = alu_eval(op, a, b);
        is_zero = (y == '0);
    end

endmodule

// File: rtl/mcdp_pc_unit.sv
module mcdp_pc_unit
    import mcdp_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pc_we,
    input  logic         br_en,
    input  logic         alu_zero,
    input  pc_src_e      pc_src,
    input  logic [W-1:0] alu_y,
    input  logic [W-1:0] alu_hold,
    input  logic [W-1:0] jtarget,
    output logic [W-1:0] pc
);

    logic [W-1:0] pc_next;
    logic         pc_load;

    always_comb begin
        case (pc_src)
            PCS_ALU:  pc_next = alu_y;
            PCS_HOLD: pc_next = alu_hold;
            PCS_JUMP: pc_next = jtarget;
            default:  pc_next = alu_y;
        endcase
        pc_load = pc_we | (br_en & alu_zero);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (pc_load) begin
            pc <= pc_next;
        end
    end

    AST_PC_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0)); // R1

    AST_PC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pc_we && !br_en) |=> $stable(pc)); // R8

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_en && alu_zero && !pc_we && pc_src == PCS_HOLD) |=> (pc == $past(alu_hold))); // R8

    AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_en && !alu_zero && !pc_we) |=> $stable(pc)); // R8

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_src == PCS_JUMP) |=> (pc == $past(jtarget))); // R9

endmodule

// File: rtl/mcdp_datapath.sv
module mcdp_datapath
    import mcdp_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctl_pc_we,
    input  logic            ctl_br_en,
    input  logic [1:0]      ctl_pc_src,
    input  logic            ctl_addr_sel,
    input  logic            ctl_mem_wr,
    input  logic            ctl_ir_we,
    input  logic            ctl_rf_we,
    input  logic            ctl_dst_rd,
    input  logic            ctl_wb_mem,
    input  logic            ctl_opa_reg,
    input  logic [1:0]      ctl_opb_sel,
    input  logic [2:0]      ctl_alu_op,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_wr,
    output logic [FLDW-1:0] opcode,
    output logic [FLDW-1:0] funct,
    output logic            zero
);

    instr_t          ir_q;
    logic [XLEN-1:0] mdr_q, opa_q, opb_q, res_q;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] rf_rd1, rf_rd2;
    logic [XLEN-1:0] alu_a, alu_b, alu_y;
    logic [XLEN-1:0] imm_ext, jtarget, wb_data;
    logic [RAW-1:0]  wr_addr;
    logic            alu_zero;

    // Holding registers behind memory, register file and ALU
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q  <= '0;
            mdr_q <= '0;
            opa_q <= '0;
            opb_q <= '0;
            res_q <= '0;
        end else begin
            mdr_q <= mem_rdata;
            opa_q <= rf_rd1;
            opb_q <= rf_rd2;
            res_q <= alu_y;
            if (ctl_ir_we) begin
                ir_q <= instr_t'(mem_rdata);
            end
        end
    end

    always_comb begin
        imm_ext = imm_sext(ir_q);
        jtarget = jump_dest(pc_q, ir_q);
        alu_a   = ctl_opa_reg ? opa_q : pc_q;
        case (opb_sel_e'(ctl_opb_sel))
            OPB_REG:      alu_b = opb_q;
            OPB_FOUR:     alu_b = XLEN'(4);
            OPB_IMM:      alu_b = imm_ext;
            OPB_IMM_WORD: alu_b = imm_ext << 2;
            default:      alu_b = opb_q;
        endcase
        wr_addr = ctl_dst_rd ? ir_q.rd[RAW-1:0] : ir_q.rt[RAW-1:0];
        wb_data = ctl_wb_mem ? mdr_q : res_q;
    end

    mcdp_regfile #(
        .NREGS (NREGS),
        .W     (XLEN)
    ) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ir_q.rs[RAW-1:0]),
        .ra2 (ir_q.rt[RAW-1:0]),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2),
        .we  (ctl_rf_we),
        .wa  (wr_addr),
        .wd  (wb_data)
    );

    mcdp_alu #(
        .W (XLEN)
    ) u_alu (
        .op      (alu_op_e'(ctl_alu_op)),
        .a       (alu_a),
        .b       (alu_b),
        .y       (alu_y),
        .is_zero (alu_zero)
    );

    mcdp_pc_unit #(
        .W (XLEN)
    ) u_pc (
        .clk      (clk),
        .rst      (rst),
        .pc_we    (ctl_pc_we),
        .br_en    (ctl_br_en),
        .alu_zero (alu_zero),
        .pc_src   (pc_src_e'(ctl_pc_src)),
        .alu_y    (alu_y),
        .alu_hold (res_q),
        .jtarget  (jtarget),
        .pc       (pc_q)
    );

    assign mem_addr  = ctl_addr_sel ? res_q : pc_q;
    assign mem_wdata = opb_q;
    assign mem_wr    = ctl_mem_wr;
    assign opcode    = ir_q.op;
    assign funct     = ir_q.fn;
    assign zero      = alu_zero;

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl_ir_we |=> $stable(ir_q)); // R12

    AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ctl_ir_we |=> (ir_q == $past(mem_rdata))); // R2

endmodule

// File: tb/mcdp_datapath_tb.sv
module mcdp_datapath_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        c_pc_we, c_br, c_addr, c_mem_wr, c_ir_we, c_rf_we, c_dst, c_wb, c_opa;
    logic [1:0]  c_pcsrc, c_opb;
    logic [2:0]  c_alu;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_wr, zero;
    logic [5:0]  opcode, funct;

    mcdp_datapath u_dut (
        .clk          (clk),
        .rst          (rst),
        .ctl_pc_we    (c_pc_we),
        .ctl_br_en    (c_br),
        .ctl_pc_src   (c_pcsrc),
        .ctl_addr_sel (c_addr),
        .ctl_mem_wr   (c_mem_wr),
        .ctl_ir_we    (c_ir_we),
        .ctl_rf_we    (c_rf_we),
        .ctl_dst_rd   (c_dst),
        .ctl_wb_mem   (c_wb),
        .ctl_opa_reg  (c_opa),
        .ctl_opb_sel  (c_opb),
        .ctl_alu_op   (c_alu),
        .mem_rdata    (mem_rdata),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wr       (mem_wr),
        .opcode       (opcode),
        .funct        (funct),
        .zero         (zero)
    );

    // Bench memory: 64 words, writes applied at the falling edge
    logic [31:0] mem [64];
    assign mem_rdata = mem[mem_addr[7:2]];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] fetched [$];

    // Behavioural reference state
    logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_out;
    logic [31:0] m_rf [32];
    logic        pend_we;
    logic [5:0]  pend_idx;
    logic [31:0] pend_data;

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] m_res();
        logic [31:0] a, b;
        a = c_opa ? m_a : m_pc;
        case (c_opb)
            2'd0: b = m_b;
            2'd1: b = 32'd4;
            2'd2: b = sx(m_ir[15:0]);
            default: b = sx(m_ir[15:0]) << 2;
        endcase
        case (c_alu)
            3'b000: return a & b;
            3'b001: return a | b;
            3'b010: return a + b;
            3'b110: return a - b;
            3'b111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] res, addr, rdata, na, nb, npc;
        logic [4:0]  wdst;
        pend_we = 1'b0;
        if (rst) begin
            m_pc = 0; m_ir = 0; m_mdr = 0; m_a = 0; m_b = 0; m_out = 0;
            for (int i = 0; i < 32; i++) m_rf[i] = 0;
        end else begin
            res   = m_res();
            addr  = c_addr ? m_out : m_pc;
            rdata = mem[addr[7:2]];
            na    = m_rf[m_ir[25:21]];
            nb    = m_rf[m_ir[20:16]];
            npc   = m_pc;
            if (c_pc_we || (c_br && res == 0)) begin
                case (c_pcsrc)
                    2'd0: npc = res;
                    2'd1: npc = m_out;
                    default: npc = {m_pc[31:28], m_ir[25:0], 2'b00};
                endcase
            end
            wdst = c_dst ? m_ir[15:11] : m_ir[20:16];
            if (c_rf_we && wdst != 0) m_rf[wdst] = c_wb ? m_mdr : m_out;
            if (c_mem_wr) begin
                pend_we = 1'b1; pend_idx = addr[7:2]; pend_data = m_b;
            end
            m_pc = npc; m_a = na; m_b = nb; m_out = res; m_mdr = rdata;
            if (c_ir_we) m_ir = rdata;
        end
    end

    always @(negedge clk) begin
        if (pend_we) mem[pend_idx] = pend_data;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_ctl();
        c_pc_we = 0; c_br = 0; c_addr = 0; c_mem_wr = 0; c_ir_we = 0; c_rf_we = 0;
        c_dst = 0; c_wb = 0; c_opa = 0; c_pcsrc = 0; c_opb = 0; c_alu = 0;
    endtask

    // Compare outputs for the cycle whose controls are already set, then advance
    task automatic cyc(input string req);
        logic [31:0] r;
        #1;
        r = m_res();
        chk(req, "mem_addr", mem_addr, c_addr ? m_out : m_pc);
        chk("R4", "mem_wdata", mem_wdata, m_b);
        chk("R4", "mem_wr", {31'd0, mem_wr}, {31'd0, c_mem_wr});
        chk("R2", "opcode", {26'd0, opcode}, {26'd0, m_ir[31:26]});
        chk("R12", "funct", {26'd0, funct}, {26'd0, m_ir[5:0]});
        chk("R5", "zero", {31'd0, zero}, {31'd0, (r == 0)});
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    task automatic exec_one(output bit halted);
        logic [5:0] op, fn;
        halted = 1'b0;
        clear_ctl(); c_ir_we = 1; c_pc_we = 1; c_opb = 1; c_alu = 3'b010;
        #1 fetched.push_back(mem_addr);
        cyc("R3");
        op = opcode; fn = funct;
        if (op == 6'h3F) begin
            halted = 1'b1;
            return;
        end
        clear_ctl(); c_opb = 3; c_alu = 3'b010;
        cyc("R6");
        case (op)
            6'd35, 6'd43: begin
                clear_ctl(); c_opa = 1; c_opb = 2; c_alu = 3'b010;
                cyc("R7");
                clear_ctl(); c_addr = 1; c_mem_wr = (op == 6'd43);
                cyc("R7");
                if (op == 6'd35) begin
                    clear_ctl(); c_rf_we = 1; c_wb = 1;
                    cyc("R10");
                end
            end
            6'd0: begin
                clear_ctl(); c_opa = 1;
                case (fn)
                    6'd32: c_alu = 3'b010;
                    6'd34: c_alu = 3'b110;
                    6'd36: c_alu = 3'b000;
                    6'd37: c_alu = 3'b001;
                    default: c_alu = 3'b111;
                endcase
                cyc("R5");
                clear_ctl(); c_rf_we = 1; c_dst = 1;
                cyc("R10");
            end
            6'd4: begin
                clear_ctl(); c_opa = 1; c_alu = 3'b110; c_br = 1; c_pcsrc = 1;
                cyc("R8");
            end
            default: begin
                clear_ctl(); c_pcsrc = 2; c_pc_we = 1;
                cyc("R9");
            end
        endcase
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_fetch [$];
        bit halted;
        clear_ctl();
        pend_we = 0;
        for (int i = 0; i < 64; i++) mem[i] = 32'hDEADBEEF;
        mem[0]  = enc_i(35, 0, 1, 'h80);          // lw r1
        mem[1]  = enc_i(35, 0, 2, 'h84);          // lw r2
        mem[2]  = enc_r(1, 2, 3, 32);             // add r3
        mem[3]  = enc_r(1, 2, 4, 34);             // sub r4
        mem[4]  = enc_r(1, 2, 5, 36);             // and r5
        mem[5]  = enc_r(1, 2, 6, 37);             // or r6
        mem[6]  = enc_r(2, 1, 7, 42);             // slt r7 = (-3 < 5)
        mem[7]  = enc_r(1, 2, 8, 42);             // slt r8 = (5 < -3)
        mem[8]  = enc_r(1, 1, 0, 32);             // write to r0
        mem[9]  = enc_i(43, 0, 3, 'h90);
        mem[10] = enc_i(43, 0, 0, 'h94);          // store r0
        mem[11] = enc_i(4, 1, 2, 5);              // not taken
        mem[12] = enc_i(4, 1, 1, 2);              // taken to 60
        mem[13] = enc_i(43, 0, 4, 'h98);
        mem[14] = enc_i(43, 0, 4, 'h9C);
        mem[15] = enc_i(35, 0, 10, 'h88);         // r10 = 0x100
        mem[16] = enc_i(43, 10, 4, -16);          // to 0xF0
        mem[17] = {6'd2, 26'd20};                 // jump to 80
        mem[18] = enc_i(43, 0, 4, 'h98);
        mem[19] = enc_i(43, 0, 4, 'h98);
        mem[20] = enc_i(43, 0, 7, 'h98);
        mem[21] = enc_i(43, 0, 5, 'hA0);
        mem[22] = enc_i(43, 0, 6, 'hA4);
        mem[23] = enc_i(43, 0, 8, 'hA8);
        mem[24] = enc_i(43, 0, 4, 'hAC);
        mem[25] = 32'hFC000000;                   // halt
        mem[32] = 32'd5;
        mem[33] = 32'hFFFFFFFD;
        mem[34] = 32'h100;

        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk("R1", "reset mem_addr", mem_addr, 0);
        chk("R1", "reset mem_wdata", mem_wdata, 0);
        chk("R1", "reset opcode", {26'd0, opcode}, 0);
        chk("R1", "reset funct", {26'd0, funct}, 0);
        chk("R1", "reset zero", {31'd0, zero}, 1);
        #1;

        halted = 0;
        while (!halted) exec_one(halted);

        for (int a = 0; a <= 48; a += 4) exp_fetch.push_back(a);
        exp_fetch.push_back(60); exp_fetch.push_back(64); exp_fetch.push_back(68);
        for (int a = 80; a <= 100; a += 4) exp_fetch.push_back(a);
        chk("R8", "fetch count", fetched.size(), exp_fetch.size());
        foreach (exp_fetch[i]) begin
            if (i < fetched.size()) chk("R9", "fetch address", fetched[i], exp_fetch[i]);
        end

        @(negedge clk);
        chk("R10", "add result", mem[36], 32'd2);
        chk("R11", "r0 stays zero", mem[37], 32'd0);
        chk("R5", "slt true", mem[38], 32'd1);
        chk("R8", "skipped store", mem[39], 32'hDEADBEEF);
        chk("R5", "and result", mem[40], 32'd5);
        chk("R5", "or result", mem[41], 32'hFFFFFFFD);
        chk("R5", "slt false", mem[42], 32'd0);
        chk("R5", "sub result", mem[43], 32'd8);
        chk("R7", "negative offset store", mem[60], 32'd8);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule